// File: doc/BRIEF.md
# Sync Source and Blanking Selector

This block picks the vertical timing reference for a display sync processor and produces horizontal and vertical blanking from it. The vertical reference is either a separate vertical sync input or a vertical sync already extracted from a composite signal. Software chooses a fixed source or an automatic mode. In automatic mode the hardware moves to the composite source on its own when that source is the only one present.

Upstream logic separates sync from the composite signal and detects which syncs are present. This block receives the results as inputs. A missing horizontal or vertical sync is replaced by a programmable steady level. HBLANK follows the effective horizontal sync. It can be kept quiet during the composite vertical interval, so that no inserted pulses appear there. Each blanking output has its own polarity bit. The three sync inputs are asynchronous and pass through a synchronizer. The source choice and the output stage are registered on the system clock.

Top module: `syncSourceBlankSel`

## Requirements
- R1: While `rstN` is low, `vsyncOut`, `hBlankOut` and `vBlankOut` are all 0.
- R2: With `srcSel` = 2'b11 the vertical source is the composite vertical sync. An absent composite (`cvPresent` = 0) reads as level 0.
- R3: With `srcSel` = 2'b10 or 2'b00 the vertical source is the effective VSYNC. Code 00 never selects the composite, whatever the presence flags are.
- R4: With `srcSel` = 2'b01 the composite is selected only when `cvPresent` = 1 and `vPresent` = 0. Every other presence combination selects the effective VSYNC.
- R5: The effective HSYNC is the synchronized `hsyncIn` when `hPresent` = 1, and `hOffHigh` otherwise. The effective VSYNC is the synchronized `vsyncIn` when `vPresent` = 1, and `vOffHigh` otherwise.
- R6: The HBLANK active interval equals the effective HSYNC. When the composite is the selected source and `noInsert` = 1, HBLANK is held inactive while the selected vertical sync is 1. With `noInsert` = 0 its pulses pass through.
- R7: `vsyncOut` is the selected vertical sync, active high. The VBLANK active interval equals it.
- R8: `hBlankNeg` = 1 inverts `hBlankOut`, and `vBlankNeg` = 1 inverts `vBlankOut`. Each bit acts only on its own output.
- R9: A change on a sync input reaches the outputs after exactly 3 rising clock edges. A change on a control or presence input reaches them after exactly 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hsyncIn | input | 1 | Horizontal sync, asynchronous, active high |
| vsyncIn | input | 1 | Separate vertical sync, asynchronous, active high |
| cvsyncIn | input | 1 | Vertical sync taken from the composite signal, asynchronous |
| hPresent | input | 1 | HSYNC present flag |
| vPresent | input | 1 | VSYNC present flag |
| cvPresent | input | 1 | Composite vertical sync present flag |
| srcSel | input | 2 | Source select: 00 off, 01 auto, 10 VSYNC, 11 composite |
| noInsert | input | 1 | 1 = no HBLANK pulses during composite vertical sync |
| hBlankNeg | input | 1 | 1 = HBLANK output active low |
| vBlankNeg | input | 1 | 1 = VBLANK output active low |
| hOffHigh | input | 1 | Level used for an absent HSYNC |
| vOffHigh | input | 1 | Level used for an absent VSYNC |
| vsyncOut | output | 1 | Selected vertical sync |
| hBlankOut | output | 1 | Horizontal blanking |
| vBlankOut | output | 1 | Vertical blanking |

## Verification
A wrong registered source choice shows as `vsyncOut` and `vBlankOut` following the wrong input. It appears two edges after the control or presence change, as soon as the two candidate syncs differ. A bad synchronizer stage moves every output edge by one cycle, so sync-path latency is checked edge by edge. A masking or polarity error shows on `hBlankOut` during the first vertical interval of composite mode, or as a steady inversion from the second edge on.

// File: rtl/syncSelPkg.sv
package syncSelPkg;

  typedef enum logic [1:0] {
    SRC_OFF   = 2'b00,
    SRC_AUTO  = 2'b01,
    SRC_VSYNC = 2'b10,
    SRC_CV    = 2'b11
  } srcCodeT;

  // Registered decisions passed from control to datapath
  typedef struct packed {
    logic useCv;   // composite is the vertical source
    logic hMask;   // suppress HBLANK during selected vertical sync
    logic hPres;
    logic vPres;
    logic cvPres;
    logic hOff;
    logic vOff;
    logic hInv;
    logic vInv;
  } selStrobeT;

endpackage

// File: rtl/syncSelCtrl.sv
module syncSelCtrl
  import syncSelPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] srcSel,
  input  logic       hPresent,
  input  logic       vPresent,
  input  logic       cvPresent,
  input  logic       noInsert,
  input  logic       hBlankNeg,
  input  logic       vBlankNeg,
  input  logic       hOffHigh,
  input  logic       vOffHigh,
  output selStrobeT  strobe
);

  srcCodeT   code;
  logic      autoFallback;
  logic      useCvNext;
  selStrobeT strobeNext;

  assign code         = srcCodeT'(srcSel);
  assign autoFallback = cvPresent & ~vPresent;

  always_comb begin
    unique case (code)
      SRC_CV:   useCvNext = 1'b1;
      SRC_AUTO: useCvNext = autoFallback;
      default:  useCvNext = 1'b0;
    endcase
  end

  always_comb begin
    strobeNext.useCv  = useCvNext;
    strobeNext.hMask  = useCvNext & noInsert;
    strobeNext.hPres  = hPresent;
    strobeNext.vPres  = vPresent;
    strobeNext.cvPres = cvPresent;
    strobeNext.hOff   = hOffHigh;
    strobeNext.vOff   = vOffHigh;
    strobeNext.hInv   = hBlankNeg;
    strobeNext.vInv   = vBlankNeg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobe <= '0;
    else       strobe <= strobeNext;
  end

  // R4
  auto_fallback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == 2'b01 && cvPresent && !vPresent) |=> strobe.useCv);

  // R4
  auto_keep_v_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == 2'b01 && !(cvPresent && !vPresent)) |=> !strobe.useCv);

  // R3
  no_cv_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == 2'b00 || srcSel == 2'b10) |=> !strobe.useCv);

  // R2
  forced_cv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == 2'b11) |=> strobe.useCv);

  // R6
  mask_needs_cv_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hMask |-> strobe.useCv);

endmodule

// File: rtl/syncSelDatapath.sv
module syncSelDatapath
  import syncSelPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      hsyncIn,
  input  logic      vsyncIn,
  input  logic      cvsyncIn,
  input  selStrobeT strobe,
  output logic      vsyncOut,
  output logic      hBlankOut,
  output logic      vBlankOut
);

  localparam int NUM_SYNC = 3;
  localparam int IDX_H    = 0;
  localparam int IDX_V    = 1;
  localparam int IDX_CV   = 2;

  logic [NUM_SYNC-1:0] rawIn;
  logic [NUM_SYNC-1:0] syncd;
  logic                hEff, vEff, cvEff, vSel, hAct;

  assign rawIn = {cvsyncIn, vsyncIn, hsyncIn};

  for (genvar g = 0; g < NUM_SYNC; g++) begin : gSync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-2:0], rawIn[g]};
    end
    assign syncd[g] = chain[SYNC_STAGES-1];
  end

  always_comb begin
    hEff  = strobe.hPres ? syncd[IDX_H] : strobe.hOff;
    vEff  = strobe.vPres ? syncd[IDX_V] : strobe.vOff;
    cvEff = strobe.cvPres & syncd[IDX_CV];
    vSel  = strobe.useCv ? cvEff : vEff;
    hAct  = hEff & ~(strobe.hMask & vSel);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vsyncOut  <= 1'b0;
      hBlankOut <= 1'b0;
      vBlankOut <= 1'b0;
    end else begin
      vsyncOut  <= vSel;
      hBlankOut <= hAct ^ strobe.hInv;
      vBlankOut <= vSel ^ strobe.vInv;
    end
  end

  // R7
  vblank_tracks_vsync_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((vBlankOut ^ vsyncOut) == $past(strobe.vInv)));

  // R5
  h_off_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.hPres && !strobe.hMask) |=> (hBlankOut == ($past(strobe.hOff) ^ $past(strobe.hInv))));

  // R6
  h_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.hMask && vSel) |=> (hBlankOut == $past(strobe.hInv)));

endmodule

// File: rtl/syncSourceBlankSel.sv
module syncSourceBlankSel
  import syncSelPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hsyncIn,
  input  logic       vsyncIn,
  input  logic       cvsyncIn,
  input  logic       hPresent,
  input  logic       vPresent,
  input  logic       cvPresent,
  input  logic [1:0] srcSel,
  input  logic       noInsert,
  input  logic       hBlankNeg,
  input  logic       vBlankNeg,
  input  logic       hOffHigh,
  input  logic       vOffHigh,
  output logic       vsyncOut,
  output logic       hBlankOut,
  output logic       vBlankOut
);

  selStrobeT strobe;

  syncSelCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .srcSel    (srcSel),
    .hPresent  (hPresent),
    .vPresent  (vPresent),
    .cvPresent (cvPresent),
    .noInsert  (noInsert),
    .hBlankNeg (hBlankNeg),
    .vBlankNeg (vBlankNeg),
    .hOffHigh  (hOffHigh),
    .vOffHigh  (vOffHigh),
    .strobe    (strobe)
  );

  syncSelDatapath #(.SYNC_STAGES(SYNC_STAGES)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .hsyncIn   (hsyncIn),
    .vsyncIn   (vsyncIn),
    .cvsyncIn  (cvsyncIn),
    .strobe    (strobe),
    .vsyncOut  (vsyncOut),
    .hBlankOut (hBlankOut),
    .vBlankOut (vBlankOut)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!rstN -> (!vsyncOut && !hBlankOut && !vBlankOut)));

endmodule

// File: tb/tb_syncSourceBlankSel.sv
module tb_syncSourceBlankSel;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hsyncIn = 0, vsyncIn = 0, cvsyncIn = 0;
  logic hPresent = 0, vPresent = 0, cvPresent = 0;
  logic [1:0] srcSel = 2'b00;
  logic noInsert = 0, hBlankNeg = 0, vBlankNeg = 0, hOffHigh = 0, vOffHigh = 0;
  logic vsyncOut, hBlankOut, vBlankOut;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 0;

  always #2 clk = ~clk;

  syncSourceBlankSel dut (
    .clk(clk), .rstN(rstN), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn), .cvsyncIn(cvsyncIn),
    .hPresent(hPresent), .vPresent(vPresent), .cvPresent(cvPresent), .srcSel(srcSel),
    .noInsert(noInsert), .hBlankNeg(hBlankNeg), .vBlankNeg(vBlankNeg),
    .hOffHigh(hOffHigh), .vOffHigh(vOffHigh),
    .vsyncOut(vsyncOut), .hBlankOut(hBlankOut), .vBlankOut(vBlankOut)
  );

  // Expected {vsyncOut, hBlankOut, vBlankOut} for inputs held steady
  function automatic logic [2:0] expectOut();
    logic useCv, hE, vE, cvE, vS, hA;
    useCv = (srcSel == 2'b11) || (srcSel == 2'b01 && cvPresent && !vPresent);
    hE  = hPresent ? hsyncIn : hOffHigh;
    vE  = vPresent ? vsyncIn : vOffHigh;
    cvE = cvPresent & cvsyncIn;
    vS  = useCv ? cvE : vE;
    hA  = hE & ~(useCv & noInsert & vS);
    return {vS, hA ^ hBlankNeg, vS ^ vBlankNeg};
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic setAll(input logic [13:0] v);
    {hsyncIn, vsyncIn, cvsyncIn, hPresent, vPresent, cvPresent, srcSel,
     noInsert, hBlankNeg, vBlankNeg, hOffHigh, vOffHigh} = v[12:0];
  endtask

  task automatic settleCheck(input string req);
    repeat (4) @(negedge clk);
    check(req, {vsyncOut, hBlankOut, vBlankOut}, expectOut());
  endtask

  initial begin
    void'($urandom(32'd4242));
    // R1: reset state, with inputs that would otherwise drive outputs high
    @(negedge clk);
    setAll(14'h1FFF);
    repeat (3) @(negedge clk);
    check("R1 reset", {vsyncOut, hBlankOut, vBlankOut}, 3'b000);
    rstN = 1'b1;

    // R2: forced composite, present and absent
    setAll('0); srcSel = 2'b11; cvPresent = 1; cvsyncIn = 1; vPresent = 1; vsyncIn = 0;
    settleCheck("R2 composite forced");
    cvPresent = 0;
    settleCheck("R2 composite absent reads 0");

    // R3: code 00 ignores the fallback condition
    srcSel = 2'b00; cvPresent = 1; cvsyncIn = 1; vPresent = 0; vOffHigh = 0;
    settleCheck("R3 code00 no composite");
    srcSel = 2'b10;
    settleCheck("R3 code10 VSYNC");

    // R4: auto mode, fallback and not
    srcSel = 2'b01;
    settleCheck("R4 auto fallback");
    vPresent = 1; vsyncIn = 0;
    settleCheck("R4 auto both present");

    // R5: off levels
    srcSel = 2'b10; hPresent = 0; hOffHigh = 1; vPresent = 0; vOffHigh = 1; hsyncIn = 0; vsyncIn = 0;
    settleCheck("R5 off levels high");

    // R6: masking in composite mode
    srcSel = 2'b11; cvPresent = 1; cvsyncIn = 1; hPresent = 1; hsyncIn = 1; noInsert = 1;
    settleCheck("R6 hblank masked");
    noInsert = 0;
    settleCheck("R6 insert pulse kept");

    // R8: polarity bits independent
    hBlankNeg = 1; vBlankNeg = 0;
    settleCheck("R8 hblank inverted only");
    hBlankNeg = 0; vBlankNeg = 1;
    settleCheck("R8 vblank inverted only");

    // R9: sync path latency of 3 edges
    setAll('0); srcSel = 2'b10; vPresent = 1;
    repeat (4) @(negedge clk);
    vsyncIn = 1;
    @(negedge clk); check("R9 sync edge1", {2'b00, vsyncOut}, 3'b000);
    @(negedge clk); check("R9 sync edge2", {2'b00, vsyncOut}, 3'b000);
    @(negedge clk); check("R9 sync edge3", {2'b00, vsyncOut}, 3'b001);
    // R9: control latency of 2 edges
    cvPresent = 1; cvsyncIn = 0;
    repeat (4) @(negedge clk);
    srcSel = 2'b11;
    @(negedge clk); check("R9 ctrl edge1", {2'b00, vsyncOut}, 3'b001);
    @(negedge clk); check("R9 ctrl edge2", {2'b00, vsyncOut}, 3'b000);

    // R7 and all others: random steady patterns
    for (int i = 0; i < 300; i++) begin
      setAll(14'($urandom));
      settleCheck("R7 random pattern");
    end

    finished = 1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

endmodule